// File: doc/BRIEF.md
# Timestamped Hex Record Serializer

This block sits behind a transponder frame decoder. Each time the decoder reports a frame, the preamble already removed, the block pairs the first three data bytes with the current value of a free-running 32-bit timestamp. The timestamp advances once per quarter millisecond. The finished record goes into a small FIFO. A record sequencer then takes records from the FIFO and sends each one as a line of uppercase ASCII hexadecimal text on an 8N1 UART line. The FIFO lets frames arrive on consecutive clocks while the serial side works at its own pace.

A line holds sixteen characters. The first six are the three frame bytes, most significant byte first and high nibble first. The next eight are the timestamp, lowest nibble first. The line ends with carriage return and line feed. If a frame arrives while the FIFO is full, that frame is discarded and a sticky overflow flag is raised.

The record sequencer has three states. In `SQ_IDLE` it pops a record whenever one is queued and moves to `SQ_ISSUE`. In `SQ_ISSUE` it hands the current character to the transmitter once the transmitter is free, then moves to `SQ_HOLD`. In `SQ_HOLD` it waits for the transmitter to free up again. After the last character it returns to `SQ_IDLE`; otherwise it steps to the next character and returns to `SQ_ISSUE`. The transmitter has four states. It leaves `TX_IDLE` on a start request. It moves from `TX_START` to `TX_DATA` after one bit time. It moves from `TX_DATA` to `TX_STOP` after the eighth data bit. It returns from `TX_STOP` to `TX_IDLE` after one bit time.

Top module: `stamp_hex_uart`

## Requirements
- R1: While reset is held, and on the first cycle after it, `tx` is 1 and `overflow` is 0. The timestamp restarts at parameter `TS_INIT` (default 0).
- R2: The timestamp increments by one every `TICK_DIV` clocks (default 2500, which is 0.25 ms at 10 MHz). After all ones it wraps to zero. Before the n-th clock edge after reset it equals `TS_INIT + floor(n / TICK_DIV)`.
- R3: A record carries the timestamp value present in the same cycle that `frame_valid` is sampled high, not the value at transmission time.
- R4: The first six characters of a record encode `frame_bytes[23:16]`, then `[15:8]`, then `[7:0]`, each byte high nibble first.
- R5: The next eight characters encode timestamp bits `[3:0]` first, then `[7:4]`, and so on up to `[31:28]`.
- R6: Each record ends with byte 0x0D and then byte 0x0A.
- R7: Nibble values 0 to 9 are sent as bytes 0x30 to 0x39. Values 10 to 15 are sent as 0x41 to 0x46.
- R8: Each character is framed as a start bit of 0, eight data bits least significant first, and a stop bit of 1. Every bit lasts `BAUD_DIV` clocks (default 87, about 115200 baud at 10 MHz). The line idles at 1.
- R9: Frames may arrive on consecutive clocks. Starting from an idle block with an empty FIFO, a burst of `DEPTH+1` frames is sent in arrival order with no loss and no overflow (one record is held by the sequencer and `DEPTH` are queued).
- R10: A frame that arrives while the FIFO holds `DEPTH` records is dropped, and `overflow` goes to 1 and stays there until reset. Records already queued are still sent intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_valid | input | 1 | One-cycle strobe marking a decoded frame |
| frame_bytes | input | DATA_BYTES*8 (24) | First data bytes after the preamble; the first byte is in the top bits |
| tx | output | 1 | UART transmit line |
| overflow | output | 1 | Sticky flag set when a frame is dropped |

## Verification
The assertions check the following on every cycle. Timestamp steps are exactly one tick period apart and add exactly one. The FIFO occupancy never exceeds its depth. The overflow flag rises only on a frame that meets a full FIFO, and it never falls. A start request is accepted only by an idle transmitter, and the line goes low on the cycle after it is accepted. Other behaviour can only be shown by the bench scenarios, which decode the serial line and compare each character with a reference built from the requirements. This covers the character order and the hex mapping, and the nibble order of the timestamp across a wrap through zero. It also covers capture of the timestamp at strobe time, and the exact boundary between a burst that fits and one that overflows.

// File: rtl/shx_pkg.sv
package shx_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_HOLD
    } seq_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } line_state_t;

    localparam logic [7:0] ASCII_CR = 8'h0D;
    localparam logic [7:0] ASCII_LF = 8'h0A;

    // nibble to uppercase hexadecimal character
    function automatic logic [7:0] hex_ascii(input logic [3:0] v);
        if (v < 4'd10) return 8'h30 + {4'h0, v};
        else           return 8'h37 + {4'h0, v};
    endfunction

endpackage

// File: rtl/shx_stamp_clock.sv
module shx_stamp_clock #(
    parameter int              TICK_DIV = 2500,
    parameter int              TS_W     = 32,
    parameter logic [TS_W-1:0] TS_INIT  = '0
) (
    input  logic            clk,
    input  logic            rst,
    output logic            tick,
    output logic [TS_W-1:0] ts
);
    localparam int            PW       = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre;

    assign tick = (pre == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre <= '0;
            ts  <= TS_INIT;
        end else if (tick) begin
            pre <= '0;
            ts  <= ts + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/shx_fifo.sv
module shx_fifo #(
    parameter int   W     = 56,
    parameter int   DEPTH = 4,
    localparam int  CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    localparam int            AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_FULL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/shx_uart_tx.sv
module shx_uart_tx
    import shx_pkg::*;
#(
    parameter int BAUD_DIV = 87
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] data,
    output logic       tx,
    output logic       ready
);
    localparam int            BW        = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
    localparam logic [BW-1:0] BAUD_LAST = BW'(BAUD_DIV - 1);

    line_state_t   st, st_nx;
    logic [BW-1:0] baud;
    logic [2:0]    bitn;
    logic [7:0]    shreg;
    logic          bit_end;

    assign bit_end = (baud == BAUD_LAST);

    always_ff @(posedge clk) begin
        if (rst) st <= TX_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE:  if (start) st_nx = TX_START;
            TX_START: if (bit_end) st_nx = TX_DATA;
            TX_DATA:  if (bit_end && bitn == 3'd7) st_nx = TX_STOP;
            TX_STOP:  if (bit_end) st_nx = TX_IDLE;
            default:  st_nx = TX_IDLE;
        endcase
    end

    always_comb begin
        tx    = 1'b1;
        ready = 1'b0;
        unique case (st)
            TX_IDLE:  ready = 1'b1;
            TX_START: tx    = 1'b0;
            TX_DATA:  tx    = shreg[0];
            TX_STOP:  tx    = 1'b1;
            default:  tx    = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            baud  <= '0;
            bitn  <= '0;
            shreg <= '0;
        end else if (st == TX_IDLE) begin
            baud <= '0;
            bitn <= '0;
            if (start) shreg <= data;
        end else begin
            baud <= bit_end ? '0 : baud + 1'b1;
            if (st == TX_DATA && bit_end) begin
                shreg <= {1'b0, shreg[7:1]};
                bitn  <= bitn + 1'b1;
            end
        end
    end
endmodule

// File: rtl/shx_record_seq.sv
module shx_record_seq
    import shx_pkg::*;
#(
    parameter int  DATA_BYTES = 3,
    parameter int  TS_W       = 32,
    localparam int REC_W      = DATA_BYTES * 8 + TS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rec_avail,
    input  logic [REC_W-1:0] rec_data,
    input  logic             uart_ready,
    output logic             rec_pop,
    output logic             char_start,
    output logic [7:0]       char_byte
);
    localparam int            DW     = DATA_BYTES * 8;
    localparam int            DN     = 2 * DATA_BYTES;
    localparam int            TN     = TS_W / 4;
    localparam int            NHEX   = DN + TN;
    localparam int            NCHARS = NHEX + 2;
    localparam int            IW     = $clog2(NCHARS);
    localparam logic [IW-1:0] LAST   = IW'(NCHARS - 1);
    localparam logic [IW-1:0] CR_POS = IW'(NCHARS - 2);
    localparam logic [IW-1:0] HEX_N  = IW'(NHEX);

    seq_state_t      st, st_nx;
    logic [DW-1:0]   held_data;
    logic [TS_W-1:0] held_ts;
    logic [IW-1:0]   idx;
    logic [3:0]      nib_tab [NHEX];

    // nibble order of one line: data high-first, then timestamp low-first
    for (genvar g = 0; g < DN; g++) begin : g_data_nib
        assign nib_tab[g] = held_data[4*(DN-1-g) +: 4];
    end
    for (genvar g = 0; g < TN; g++) begin : g_ts_nib
        assign nib_tab[DN+g] = held_ts[4*g +: 4];
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SQ_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            SQ_IDLE:  if (rec_avail) st_nx = SQ_ISSUE;
            SQ_ISSUE: if (uart_ready) st_nx = SQ_HOLD;
            SQ_HOLD:  if (uart_ready) st_nx = (idx == LAST) ? SQ_IDLE : SQ_ISSUE;
            default:  st_nx = SQ_IDLE;
        endcase
    end

    always_comb begin
        rec_pop    = 1'b0;
        char_start = 1'b0;
        unique case (st)
            SQ_IDLE:  rec_pop    = rec_avail;
            SQ_ISSUE: char_start = uart_ready;
            SQ_HOLD:  ;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_data <= '0;
            held_ts   <= '0;
            idx       <= '0;
        end else if (st == SQ_IDLE && rec_avail) begin
            held_data <= rec_data[REC_W-1 -: DW];
            held_ts   <= rec_data[TS_W-1:0];
            idx       <= '0;
        end else if (st == SQ_HOLD && uart_ready && idx != LAST) begin
            idx <= idx + 1'b1;
        end
    end

    always_comb begin
        if (idx < HEX_N)        char_byte = hex_ascii(nib_tab[idx]);
        else if (idx == CR_POS) char_byte = ASCII_CR;
        else                    char_byte = ASCII_LF;
    end
endmodule

// File: rtl/stamp_hex_uart.sv
module stamp_hex_uart #(
    parameter int              DATA_BYTES = 3,
    parameter int              TS_W       = 32,
    parameter int              TICK_DIV   = 2500,
    parameter int              BAUD_DIV   = 87,
    parameter int              DEPTH      = 4,
    parameter logic [TS_W-1:0] TS_INIT    = '0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_valid,
    input  logic [DATA_BYTES*8-1:0] frame_bytes,
    output logic                    tx,
    output logic                    overflow
);
    localparam int DW    = DATA_BYTES * 8;
    localparam int REC_W = DW + TS_W;
    localparam int CW    = $clog2(DEPTH + 1);

    logic             tick;
    logic [TS_W-1:0]  ts_now;
    logic             fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [REC_W-1:0] fifo_dout;
    logic [CW-1:0]    fifo_count;
    logic             uart_start, uart_ready;
    logic [7:0]       uart_byte;

    assign fifo_push = frame_valid && !fifo_full;

    always_ff @(posedge clk) begin
        if (rst)                           overflow <= 1'b0;
        else if (frame_valid && fifo_full) overflow <= 1'b1;
    end

    shx_stamp_clock #(
        .TICK_DIV (TICK_DIV),
        .TS_W     (TS_W),
        .TS_INIT  (TS_INIT)
    ) u_clock (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .ts   (ts_now)
    );

    shx_fifo #(
        .W     (REC_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .din   ({frame_bytes, ts_now}),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_count)
    );

    shx_record_seq #(
        .DATA_BYTES (DATA_BYTES),
        .TS_W       (TS_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .rec_avail  (!fifo_empty),
        .rec_data   (fifo_dout),
        .uart_ready (uart_ready),
        .rec_pop    (fifo_pop),
        .char_start (uart_start),
        .char_byte  (uart_byte)
    );

    shx_uart_tx #(
        .BAUD_DIV (BAUD_DIV)
    ) u_uart (
        .clk   (clk),
        .rst   (rst),
        .start (uart_start),
        .data  (uart_byte),
        .tx    (tx),
        .ready (uart_ready)
    );
endmodule

// File: rtl/shx_checker.sv
module shx_checker #(
    parameter int TICK_DIV = 2500,
    parameter int TS_W     = 32,
    parameter int DEPTH    = 4,
    parameter int CW       = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            frame_valid,
    input logic            tx,
    input logic            overflow,
    input logic            tick,
    input logic [TS_W-1:0] ts_now,
    input logic            fifo_full,
    input logic [CW-1:0]   fifo_count,
    input logic            uart_start,
    input logic            uart_ready
);
    int gap;

    always_ff @(posedge clk) begin
        if (rst || tick) gap <= 0;
        else             gap <= gap + 1;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (tx && !overflow));

    a_r2_tick_period: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap == TICK_DIV - 1));

    a_r2_ts_step: assert property (@(posedge clk) disable iff (rst)
        tick |=> (ts_now == $past(ts_now) + 1'b1));

    a_r2_ts_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(ts_now));

    a_r9_fifo_bound: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH));

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    a_r10_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(frame_valid && fifo_full));

    a_r8_start_when_idle: assert property (@(posedge clk) disable iff (rst)
        uart_start |-> uart_ready);

    a_r8_start_bit_low: assert property (@(posedge clk) disable iff (rst)
        (uart_start && uart_ready) |=> !tx);
endmodule

bind stamp_hex_uart shx_checker #(
    .TICK_DIV (TICK_DIV),
    .TS_W     (TS_W),
    .DEPTH    (DEPTH),
    .CW       (CW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_valid (frame_valid),
    .tx          (tx),
    .overflow    (overflow),
    .tick        (tick),
    .ts_now      (ts_now),
    .fifo_full   (fifo_full),
    .fifo_count  (fifo_count),
    .uart_start  (uart_start),
    .uart_ready  (uart_ready)
);

// File: tb/stamp_hex_uart_tb.sv
module stamp_hex_uart_tb;
    localparam int          DEPTH    = 4;
    localparam int          TICK_DIV = 8;
    localparam int          BAUD_DIV = 4;
    localparam logic [31:0] TS_INIT  = 32'hFFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_valid = 1'b0;
    logic [23:0] frame_bytes = '0;
    logic        tx, overflow;

    int vectors = 0;
    int fails   = 0;
    int edge_n  = 0;
    int char_pos = 0;
    logic m_ovf   = 1'b0;
    logic drop_now = 1'b0;
    logic [7:0] exp_q [$];

    always #2 clk = ~clk;

    stamp_hex_uart #(
        .DATA_BYTES (3),
        .TS_W       (32),
        .TICK_DIV   (TICK_DIV),
        .BAUD_DIV   (BAUD_DIV),
        .DEPTH      (DEPTH),
        .TS_INIT    (TS_INIT)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (frame_valid),
        .frame_bytes (frame_bytes),
        .tx          (tx),
        .overflow    (overflow)
    );

    function automatic logic [7:0] ref_hex(input logic [3:0] v);
        if (v < 4'd10) return 8'd48 + 8'(v);
        return 8'd65 + 8'(v) - 8'd10;
    endfunction

    // reference record: R4 data high nibble first, R5 timestamp low nibble first, R6 CR LF
    task automatic add_record(input logic [23:0] d, input logic [31:0] t);
        for (int i = 0; i < 6; i++) exp_q.push_back(ref_hex(d[4*(5-i) +: 4]));
        for (int i = 0; i < 8; i++) exp_q.push_back(ref_hex(t[4*i +: 4]));
        exp_q.push_back(8'h0D);
        exp_q.push_back(8'h0A);
    endtask

    // R2 model: timestamp value before the upcoming edge
    function automatic logic [31:0] ref_ts();
        return TS_INIT + 32'(edge_n / TICK_DIV);
    endfunction

    always @(posedge clk) begin
        if (rst) edge_n <= 0;
        else     edge_n <= edge_n + 1;
    end

    // R10 model flag
    always @(posedge clk) begin
        if (rst) m_ovf <= 1'b0;
        else if (frame_valid && drop_now) m_ovf <= 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            vectors++;
            if (overflow !== m_ovf) begin
                fails++;
                $display("FAIL R10 overflow flag at edge %0d: got %0b expected %0b", edge_n, overflow, m_ovf);
            end
        end
    end

    task automatic check_char(input logic [7:0] b, input logic stop_ok);
        logic [7:0] e;
        string tag;
        vectors++;
        if (char_pos < 6) tag = "R4";
        else if (char_pos < 14) tag = "R5";
        else tag = "R6";
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R9 unexpected char: got %02h expected none", b);
        end else begin
            e = exp_q.pop_front();
            if (b !== e || stop_ok !== 1'b1) begin
                fails++;
                $display("FAIL %s/R7/R8 char %0d: got %02h stop %0b expected %02h stop 1",
                         tag, char_pos, b, stop_ok, e);
            end
        end
        char_pos = (char_pos == 15) ? 0 : char_pos + 1;
    endtask

    // serial line decoder, samples mid-bit (R8)
    initial begin : rx_decode
        logic [7:0] b;
        logic       stop_ok;
        forever begin
            @(negedge clk);
            if (!rst && tx === 1'b0) begin
                repeat (BAUD_DIV / 2) @(negedge clk);
                for (int k = 0; k < 8; k++) begin
                    repeat (BAUD_DIV) @(negedge clk);
                    b[k] = tx;
                end
                repeat (BAUD_DIV) @(negedge clk);
                stop_ok = tx;
                check_char(b, stop_ok);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic send_one(input logic [23:0] d);
        @(negedge clk);
        frame_valid = 1'b1;
        frame_bytes = d;
        drop_now    = 1'b0;
        add_record(d, ref_ts());
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    // back-to-back burst starting from an idle block (R9, R10)
    task automatic send_burst(input int n, input logic [23:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_valid = 1'b1;
            frame_bytes = base + 24'(i) * 24'h010203;
            if (i <= DEPTH) begin
                drop_now = 1'b0;
                add_record(frame_bytes, ref_ts());
            end else begin
                drop_now = 1'b1;
            end
        end
        @(negedge clk);
        frame_valid = 1'b0;
        drop_now    = 1'b0;
    endtask

    task automatic wait_drain();
        wait (exp_q.size() == 0);
        repeat (BAUD_DIV * 12) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: pending chars got %0d expected 0", exp_q.size());
        finish_run();
    end

    initial begin : main
        repeat (5) @(negedge clk);
        // R1: reset state
        check_bit("R1 tx in reset", tx, 1'b1);
        check_bit("R1 overflow in reset", overflow, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R1 tx after reset", tx, 1'b1);
        check_bit("R1 overflow after reset", overflow, 1'b0);

        // R3, R4, R5, R7: timestamp near the top of the range, mixed digits and letters
        repeat (9) @(negedge clk);
        send_one(24'h12AB3F);
        wait_drain();

        // R2: timestamp has wrapped through zero by now
        send_one(24'hFEDCBA);
        send_one(24'h000009);
        wait_drain();

        // R9: burst that fits exactly
        send_burst(DEPTH + 1, 24'h405060);
        @(negedge clk);
        check_bit("R9 no overflow after fitting burst", overflow, 1'b0);
        wait_drain();

        // R10: burst exceeding capacity
        send_burst(DEPTH + 3, 24'hA0B0C0);
        @(negedge clk);
        check_bit("R10 overflow after long burst", overflow, 1'b1);
        wait_drain();

        // R10: flag stays set, later frames still sent
        send_one(24'h5A5A5A);
        wait_drain();
        check_bit("R10 overflow sticky", overflow, 1'b1);

        vectors++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R9 records left unsent: got %0d expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule